// File: doc/BRIEF.md
# E1 Interval Error Counter Bank

This block accumulates receive-side performance events for one E1 framer channel over a measurement interval. At the end of each interval it moves the totals into holding registers that a host can read. The framer supplies per-frame strobes:

- the received alignment word of each alignment frame;
- bit 2 of timeslot 0 of each non-alignment frame;
- the count of remote block error indications carried in the E bits;
- CRC-4 compare results;
- basic-frame and CRC-multiframe sync status.

The block does no alignment search and no CRC computation of its own.

Three running counters track alignment errors, remote block errors and CRC errors. Two control bits choose how alignment errors are counted. Sync loss freezes the counters. A group transfer copies all three counters into their holding registers and restarts the counts from zero. Three sources can trigger a transfer:

- a programmable interval timer driven by a frame-rate tick;
- a host write to any holding register;
- a strobe shared by all channels.

Each transfer raises a flag that can drive an interrupt. An overrun flag reports that a transfer replaced a holding value the host had not read.

The host port is a single-cycle read/write interface with registered read data. Its register map is:

| Address | Contents | Notes |
|---|---|---|
| 0 | Control: bit0 enables the interval timer, bit1 enables the interrupt, bits 3:2 select the alignment rule | Read/write |
| 1 | Status: bit0 transfer flag, bit1 overrun flag | Reading clears both flags |
| 2 | Alignment error holding register | A write triggers a transfer |
| 3 | Remote block error holding register | A write triggers a transfer |
| 4 | CRC error holding register | A write triggers a transfer |
| 5 | Interval length, in frame ticks | Read/write |

Top module: `e1_err_interval_bank`

## Requirements
- R1: After synchronous reset, all holding registers read 0, the transfer flag, overrun flag and irq are 0, the control register reads 0 and the interval register reads PRESC_DEFAULT (8000).
- R2: `fas_word` is compared against 7'b0011011. With rule 00, each mismatching bit counts one. With rule 01, each mismatching bit counts one, and a 0 on `nfas_bit2` at a `nfas_valid` strobe also counts one.
- R3: With rule 10, an alignment word with any mismatch counts exactly one. With rule 11, one error is counted at the next `nfas_valid` strobe if the preceding alignment word had any mismatch or `nfas_bit2` is 0; nothing is counted at the alignment word itself.
- R4: The remote block error counter adds `rbe_cnt` (0 to 2) every cycle. The CRC error counter adds one for each cycle with `crc_valid` and `crc_mismatch` both high.
- R5: While `bfa_sync` is 0, none of the three counters changes. While `mfa_sync` is 0, the remote block error and CRC error counters do not change, but alignment errors are still counted.
- R6: Each running counter stops at its all-ones value (127 for alignment errors) and does not wrap.
- R7: A group transfer copies all three counters into the holding registers at the same clock edge. It is triggered by a host write to address 2, 3 or 4, by `global_update`, or, when control bit0 is 1, on the frame tick that completes each interval. Holding registers change at no other time.
- R8: A transfer restarts every running counter. An event presented in the same cycle as the transfer is counted in the new interval.
- R9: Every transfer sets the transfer flag. `irq` is 1 exactly while the transfer flag is 1 and control bit1 is 1.
- R10: A transfer sets the overrun flag if any holding register has not been read since the previous transfer. Reading a holding register marks it as read.
- R11: The control register and the interval register read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One pulse per basic frame; drives the interval timer |
| fas_valid | input | 1 | Strobe: `fas_word` holds a received alignment word |
| fas_word | input | 7 | Received alignment word bits |
| nfas_valid | input | 1 | Strobe: a non-alignment frame was received |
| nfas_bit2 | input | 1 | Bit 2 of timeslot 0 of that non-alignment frame |
| rbe_cnt | input | 2 | Number of E-bit block error indications this cycle |
| crc_valid | input | 1 | A CRC-4 compare result is available |
| crc_mismatch | input | 1 | The compare failed |
| bfa_sync | input | 1 | Basic frame alignment is held |
| mfa_sync | input | 1 | CRC multiframe alignment is held |
| global_update | input | 1 | Transfer strobe shared by all channels |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_addr | input | 3 | Host register address |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Read data, valid the cycle after `reg_rd` |
| fer_hold | output | 7 | Latched alignment error count |
| rbe_hold | output | 10 | Latched remote block error count |
| crc_hold | output | 10 | Latched CRC error count |
| xfer_flag | output | 1 | Transfer has occurred since the last status read |
| ovr_flag | output | 1 | Unread holding value was overwritten |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is an event arriving in the same cycle as a transfer. The event must land in the new interval and not in the value being latched. The bench drives an alignment word strobe in the same cycle as a host write to a holding address, then checks two things: the latched value excludes that event, and the following transfer includes it.

Rule 11 needs an alignment frame followed by a non-alignment frame. The bench checks each combination of good and bad halves of that pair.

Saturation needs more errors than the counter can hold, so twenty all-wrong alignment words are sent within one interval.

Overrun is reached in two ways: by back-to-back global strobes, and by reading only some of the holding registers before a transfer.

// File: rtl/e1pm_pkg.sv
package e1pm_pkg;

  // Expected content of the alignment word as presented on fas_word
  localparam logic [6:0] ALIGN_PATTERN = 7'b0011011;

  // Width of a single-cycle alignment error increment (at most 7 + 1)
  localparam int unsigned INC_W = 4;

  typedef enum logic [1:0] {
    RULE_PER_BIT      = 2'b00,
    RULE_PER_BIT_NFAS = 2'b01,
    RULE_PER_WORD     = 2'b10,
    RULE_WORD_PAIR    = 2'b11
  } align_rule_e;

  localparam logic [2:0] ADR_CTRL   = 3'd0;
  localparam logic [2:0] ADR_STATUS = 3'd1;
  localparam logic [2:0] ADR_FER    = 3'd2;
  localparam logic [2:0] ADR_RBE    = 3'd3;
  localparam logic [2:0] ADR_CRC    = 3'd4;
  localparam logic [2:0] ADR_PRESC  = 3'd5;

endpackage

// File: rtl/e1pm_fas_rule.sv
module e1pm_fas_rule
  import e1pm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  align_rule_e       rule,
  input  logic              fas_valid,
  input  logic [6:0]        fas_word,
  input  logic              nfas_valid,
  input  logic              nfas_bit2,
  output logic [INC_W-1:0]  inc
);

  logic [6:0]       err_bits;
  logic [INC_W-1:0] err_count;
  logic             word_bad;
  logic             nfas_bad;
  logic             pend_q;
  logic [INC_W-1:0] raw_inc;

  assign err_bits = fas_word ^ ALIGN_PATTERN;
  assign word_bad = |err_bits;
  assign nfas_bad = ~nfas_bit2;

  always_comb begin
    err_count = '0;
    for (int i = 0; i < 7; i++) begin
      err_count = err_count + INC_W'(err_bits[i]);
    end
  end

  // Outcome of the last alignment word, awaiting the following NFAS frame
  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      pend_q <= 1'b0;
    end else if (fas_valid) begin
      pend_q <= word_bad;
    end else if (nfas_valid) begin
      pend_q <= 1'b0;
    end
  end

  always_comb begin
    raw_inc = '0;
    unique case (rule)
      RULE_PER_BIT: begin
        if (fas_valid) raw_inc = err_count;
      end
      RULE_PER_BIT_NFAS: begin
        raw_inc = (fas_valid ? err_count : '0) +
                  INC_W'(nfas_valid && nfas_bad);
      end
      RULE_PER_WORD: begin
        raw_inc = INC_W'(fas_valid && word_bad);
      end
      RULE_WORD_PAIR: begin
        raw_inc = INC_W'(nfas_valid && (pend_q || nfas_bad));
      end
      default: raw_inc = '0;
    endcase
  end

  assign inc = enable ? raw_inc : '0;

endmodule

// File: rtl/e1pm_sat_counter.sv
module e1pm_sat_counter #(
  parameter int unsigned WIDTH = 10,
  parameter int unsigned INC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [INC_W-1:0] inc,
  output logic [WIDTH-1:0] count
);

  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  logic [WIDTH-1:0] base;
  logic [WIDTH:0]   sum;

  assign base = restart ? '0 : count;
  assign sum  = {1'b0, base} + (WIDTH+1)'(inc);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (sum[WIDTH]) begin
      count <= TOP;
    end else begin
      count <= sum[WIDTH-1:0];
    end
  end

endmodule

// File: rtl/e1pm_interval_timer.sv
module e1pm_interval_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             tick,
  input  logic [CNT_W-1:0] length,
  output logic             expire
);

  logic [CNT_W-1:0] ticks_q;
  logic [CNT_W-1:0] last;

  assign last   = (length == '0) ? '0 : length - 1'b1;
  assign expire = enable && tick && (ticks_q >= last);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      ticks_q <= '0;
    end else if (tick) begin
      ticks_q <= (ticks_q >= last) ? '0 : ticks_q + 1'b1;
    end
  end

endmodule

// File: rtl/e1_err_interval_bank.sv
module e1_err_interval_bank
  import e1pm_pkg::*;
#(
  parameter int unsigned FER_W         = 7,
  parameter int unsigned RBE_W         = 10,
  parameter int unsigned CRC_W         = 10,
  parameter int unsigned PRESC_W       = 16,
  parameter int unsigned PRESC_DEFAULT = 8000,
  parameter int unsigned ADDR_W        = 3,
  parameter int unsigned DATA_W        = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_tick,
  input  logic              fas_valid,
  input  logic [6:0]        fas_word,
  input  logic              nfas_valid,
  input  logic              nfas_bit2,
  input  logic [1:0]        rbe_cnt,
  input  logic              crc_valid,
  input  logic              crc_mismatch,
  input  logic              bfa_sync,
  input  logic              mfa_sync,
  input  logic              global_update,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [FER_W-1:0]  fer_hold,
  output logic [RBE_W-1:0]  rbe_hold,
  output logic [CRC_W-1:0]  crc_hold,
  output logic              xfer_flag,
  output logic              ovr_flag,
  output logic              irq
);

  localparam int unsigned NUM_HOLD = 3;

  logic              auto_en_q;
  logic              irq_en_q;
  align_rule_e       rule_q;
  logic [PRESC_W-1:0] presc_q;

  logic [INC_W-1:0]  fer_inc;
  logic [INC_W-1:0]  rbe_inc;
  logic [INC_W-1:0]  crc_inc;
  logic [FER_W-1:0]  fer_cnt;
  logic [RBE_W-1:0]  rbe_run;
  logic [CRC_W-1:0]  crc_cnt;

  logic              timer_expire;
  logic              host_hold_wr;
  logic              xfer_now;
  logic              status_rd;
  logic [NUM_HOLD-1:0] hold_rd;
  logic [NUM_HOLD-1:0] unread_q;
  logic              xfer_flag_n;
  logic              irq_en_n;
  logic              mf_ok;

  // ---------------- host decode ----------------
  assign host_hold_wr = reg_wr && ((reg_addr == ADDR_W'(ADR_FER)) ||
                                   (reg_addr == ADDR_W'(ADR_RBE)) ||
                                   (reg_addr == ADDR_W'(ADR_CRC)));
  assign status_rd = reg_rd && (reg_addr == ADDR_W'(ADR_STATUS));

  generate
    for (genvar h = 0; h < NUM_HOLD; h++) begin : g_hold_rd
      assign hold_rd[h] = reg_rd && (reg_addr == ADDR_W'(ADR_FER) + ADDR_W'(h));
    end
  endgenerate

  assign xfer_now = global_update || host_hold_wr || timer_expire;

  // ---------------- control registers ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      auto_en_q <= 1'b0;
      irq_en_q  <= 1'b0;
      rule_q    <= RULE_PER_BIT;
      presc_q   <= PRESC_W'(PRESC_DEFAULT);
    end else if (reg_wr) begin
      if (reg_addr == ADDR_W'(ADR_CTRL)) begin
        auto_en_q <= reg_wdata[0];
        irq_en_q  <= reg_wdata[1];
        rule_q    <= align_rule_e'(reg_wdata[3:2]);
      end else if (reg_addr == ADDR_W'(ADR_PRESC)) begin
        presc_q   <= PRESC_W'(reg_wdata);
      end
    end
  end

  // ---------------- event sources ----------------
  e1pm_fas_rule u_rule (
    .clk        (clk),
    .rst        (rst),
    .enable     (bfa_sync),
    .rule       (rule_q),
    .fas_valid  (fas_valid),
    .fas_word   (fas_word),
    .nfas_valid (nfas_valid),
    .nfas_bit2  (nfas_bit2),
    .inc        (fer_inc)
  );

  assign mf_ok   = bfa_sync && mfa_sync;
  assign rbe_inc = mf_ok ? INC_W'(rbe_cnt) : '0;
  assign crc_inc = INC_W'(mf_ok && crc_valid && crc_mismatch);

  // ---------------- running counters ----------------
  e1pm_sat_counter #(.WIDTH(FER_W), .INC_W(INC_W)) u_fer_cnt (
    .clk (clk), .rst (rst), .restart (xfer_now), .inc (fer_inc), .count (fer_cnt)
  );

  e1pm_sat_counter #(.WIDTH(RBE_W), .INC_W(INC_W)) u_rbe_cnt (
    .clk (clk), .rst (rst), .restart (xfer_now), .inc (rbe_inc), .count (rbe_run)
  );

  e1pm_sat_counter #(.WIDTH(CRC_W), .INC_W(INC_W)) u_crc_cnt (
    .clk (clk), .rst (rst), .restart (xfer_now), .inc (crc_inc), .count (crc_cnt)
  );

  e1pm_interval_timer #(.CNT_W(PRESC_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .enable (auto_en_q),
    .tick   (frame_tick),
    .length (presc_q),
    .expire (timer_expire)
  );

  // ---------------- holding registers ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      fer_hold <= '0;
      rbe_hold <= '0;
      crc_hold <= '0;
    end else if (xfer_now) begin
      fer_hold <= fer_cnt;
      rbe_hold <= rbe_run;
      crc_hold <= crc_cnt;
    end
  end

  // ---------------- read tracking and flags ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      unread_q <= '0;
    end else if (xfer_now) begin
      unread_q <= '1;
    end else begin
      unread_q <= unread_q & ~hold_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_flag <= 1'b0;
    end else if (xfer_now && (|unread_q)) begin
      ovr_flag <= 1'b1;
    end else if (status_rd) begin
      ovr_flag <= 1'b0;
    end
  end

  always_comb begin
    xfer_flag_n = xfer_flag;
    if (xfer_now) begin
      xfer_flag_n = 1'b1;
    end else if (status_rd) begin
      xfer_flag_n = 1'b0;
    end
    irq_en_n = irq_en_q;
    if (reg_wr && (reg_addr == ADDR_W'(ADR_CTRL))) begin
      irq_en_n = reg_wdata[1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xfer_flag <= 1'b0;
      irq       <= 1'b0;
    end else begin
      xfer_flag <= xfer_flag_n;
      irq       <= xfer_flag_n && irq_en_n;
    end
  end

  // ---------------- read data ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      unique case (reg_addr)
        ADDR_W'(ADR_CTRL):   reg_rdata <= DATA_W'({rule_q, irq_en_q, auto_en_q});
        ADDR_W'(ADR_STATUS): reg_rdata <= DATA_W'({ovr_flag, xfer_flag});
        ADDR_W'(ADR_FER):    reg_rdata <= DATA_W'(fer_hold);
        ADDR_W'(ADR_RBE):    reg_rdata <= DATA_W'(rbe_hold);
        ADDR_W'(ADR_CRC):    reg_rdata <= DATA_W'(crc_hold);
        ADDR_W'(ADR_PRESC):  reg_rdata <= DATA_W'(presc_q);
        default:             reg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/e1_err_interval_bank_chk.sv
module e1_err_interval_bank_chk #(
  parameter int unsigned FER_W = 7,
  parameter int unsigned RBE_W = 10,
  parameter int unsigned CRC_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             xfer_now,
  input logic             bfa_sync,
  input logic             mfa_sync,
  input logic [FER_W-1:0] fer_cnt,
  input logic [RBE_W-1:0] rbe_run,
  input logic [CRC_W-1:0] crc_cnt,
  input logic [FER_W-1:0] fer_hold,
  input logic [RBE_W-1:0] rbe_hold,
  input logic [CRC_W-1:0] crc_hold,
  input logic             xfer_flag,
  input logic             ovr_flag,
  input logic             irq
);

  AST_HOLD_ONLY_ON_XFER: assert property (@(posedge clk) disable iff (rst)
    !xfer_now |=> ($stable(fer_hold) && $stable(rbe_hold) && $stable(crc_hold))); // R7

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    !xfer_now |=> (fer_cnt >= $past(fer_cnt) && rbe_run >= $past(rbe_run) && crc_cnt >= $past(crc_cnt))); // R6

  AST_BFA_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (!bfa_sync && !xfer_now) |=> ($stable(fer_cnt) && $stable(rbe_run) && $stable(crc_cnt))); // R5

  AST_MFA_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (!mfa_sync && !xfer_now) |=> ($stable(rbe_run) && $stable(crc_cnt))); // R5

  AST_RESTART: assert property (@(posedge clk) disable iff (rst)
    xfer_now |=> (fer_cnt <= FER_W'(8) && rbe_run <= RBE_W'(2) && crc_cnt <= CRC_W'(1))); // R8

  AST_XFER_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    xfer_now |=> xfer_flag); // R9

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq |-> xfer_flag); // R9

  AST_OVR_FROM_XFER: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_flag) |-> $past(xfer_now)); // R10

endmodule

bind e1_err_interval_bank e1_err_interval_bank_chk #(
  .FER_W (FER_W),
  .RBE_W (RBE_W),
  .CRC_W (CRC_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .xfer_now  (xfer_now),
  .bfa_sync  (bfa_sync),
  .mfa_sync  (mfa_sync),
  .fer_cnt   (fer_cnt),
  .rbe_run   (rbe_run),
  .crc_cnt   (crc_cnt),
  .fer_hold  (fer_hold),
  .rbe_hold  (rbe_hold),
  .crc_hold  (crc_hold),
  .xfer_flag (xfer_flag),
  .ovr_flag  (ovr_flag),
  .irq       (irq)
);

// File: tb/e1_err_interval_bank_tb.sv
module e1_err_interval_bank_tb;

  localparam int CLK_PERIOD = 10;

  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_FER = 3'd2,
                         A_RBE = 3'd3, A_CRC = 3'd4, A_PRESC = 3'd5;

  // {rule[1:0], fas_word[6:0], nfas_bit2, expected alignment errors[3:0]}
  localparam int NVEC = 11;
  localparam logic [13:0] VEC [NVEC] = '{
    {2'b00, 7'b0011011, 1'b1, 4'd0},
    {2'b00, 7'b0011010, 1'b0, 4'd1},
    {2'b00, 7'b1100100, 1'b1, 4'd7},
    {2'b01, 7'b0011011, 1'b0, 4'd1},
    {2'b01, 7'b0011000, 1'b0, 4'd3},
    {2'b10, 7'b1100100, 1'b0, 4'd1},
    {2'b10, 7'b0011011, 1'b0, 4'd0},
    {2'b11, 7'b0011011, 1'b0, 4'd1},
    {2'b11, 7'b0111011, 1'b1, 4'd1},
    {2'b11, 7'b1111111, 1'b0, 4'd1},
    {2'b11, 7'b0011011, 1'b1, 4'd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_tick = 0, fas_valid = 0, nfas_valid = 0, nfas_bit2 = 1;
  logic [6:0]  fas_word = 7'b0011011;
  logic [1:0]  rbe_cnt = 0;
  logic        crc_valid = 0, crc_mismatch = 0;
  logic        bfa_sync = 1, mfa_sync = 1, global_update = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [2:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic [6:0]  fer_hold;
  logic [9:0]  rbe_hold, crc_hold;
  logic        xfer_flag, ovr_flag, irq;

  int n_checks = 0;
  int n_fails  = 0;
  logic [15:0] rd_val;

  always #(CLK_PERIOD/2) clk = ~clk;

  e1_err_interval_bank u_dut (
    .clk(clk), .rst(rst), .frame_tick(frame_tick), .fas_valid(fas_valid),
    .fas_word(fas_word), .nfas_valid(nfas_valid), .nfas_bit2(nfas_bit2),
    .rbe_cnt(rbe_cnt), .crc_valid(crc_valid), .crc_mismatch(crc_mismatch),
    .bfa_sync(bfa_sync), .mfa_sync(mfa_sync), .global_update(global_update),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .fer_hold(fer_hold), .rbe_hold(rbe_hold),
    .crc_hold(crc_hold), .xfer_flag(xfer_flag), .ovr_flag(ovr_flag), .irq(irq)
  );

  task automatic check(input string req, input int actual, input int expected);
    n_checks++;
    if (actual != expected) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic send_fas(input logic [6:0] w);
    @(negedge clk); fas_valid = 1; fas_word = w;
    @(negedge clk); fas_valid = 0; fas_word = 7'b0011011;
  endtask

  task automatic send_nfas(input logic b);
    @(negedge clk); nfas_valid = 1; nfas_bit2 = b;
    @(negedge clk); nfas_valid = 0; nfas_bit2 = 1;
  endtask

  task automatic pulse_global();
    @(negedge clk); global_update = 1;
    @(negedge clk); global_update = 0;
  endtask

  task automatic tick();
    @(negedge clk); frame_tick = 1;
    @(negedge clk); frame_tick = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    check("R1 fer_hold", fer_hold, 0);
    check("R1 rbe_hold", rbe_hold, 0);
    check("R1 crc_hold", crc_hold, 0);
    check("R1 flags", {ovr_flag, xfer_flag, irq}, 0);
    rd(A_CTRL, rd_val);  check("R1 ctrl", rd_val, 0);
    rd(A_PRESC, rd_val); check("R1 interval", rd_val, 8000);

    // R11 register readback
    wr(A_PRESC, 16'd1234);
    rd(A_PRESC, rd_val); check("R11 interval", rd_val, 1234);
    wr(A_CTRL, 16'b1010);
    rd(A_CTRL, rd_val);  check("R11 ctrl", rd_val, 16'b1010);
    wr(A_CTRL, 16'd0);

    // R2 / R3 alignment rules from the vector table
    for (int i = 0; i < NVEC; i++) begin
      wr(A_CTRL, {12'd0, VEC[i][13:12], 2'b00});
      wr(A_FER, 16'd0);
      send_fas(VEC[i][11:5]);
      send_nfas(VEC[i][4]);
      wr(A_FER, 16'd0);
      check(VEC[i][13] ? "R3 rule vector" : "R2 rule vector", fer_hold, VEC[i][3:0]);
    end

    // R4 remote block and CRC counting
    wr(A_CTRL, 16'd0);
    wr(A_FER, 16'd0);
    @(negedge clk); rbe_cnt = 2;
    @(negedge clk); rbe_cnt = 1;
    @(negedge clk); rbe_cnt = 2;
    @(negedge clk); rbe_cnt = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); crc_valid = 1; crc_mismatch = (k < 4);
    end
    @(negedge clk); crc_valid = 0; crc_mismatch = 0;
    crc_mismatch = 1;
    @(negedge clk); crc_mismatch = 0;   // mismatch without valid: ignored
    wr(A_RBE, 16'd0);
    check("R4 rbe count", rbe_hold, 5);
    check("R4 crc count", crc_hold, 4);

    // R5 sync gating
    bfa_sync = 0;
    send_fas(7'b1100100);
    @(negedge clk); rbe_cnt = 2; crc_valid = 1; crc_mismatch = 1;
    @(negedge clk); rbe_cnt = 0; crc_valid = 0; crc_mismatch = 0;
    wr(A_CRC, 16'd0);
    check("R5 bfa loss fer", fer_hold, 0);
    check("R5 bfa loss rbe", rbe_hold, 0);
    check("R5 bfa loss crc", crc_hold, 0);
    bfa_sync = 1; mfa_sync = 0;
    send_fas(7'b1100100);
    @(negedge clk); rbe_cnt = 2; crc_valid = 1; crc_mismatch = 1;
    @(negedge clk); rbe_cnt = 0; crc_valid = 0; crc_mismatch = 0;
    wr(A_CRC, 16'd0);
    check("R5 mfa loss fer", fer_hold, 7);
    check("R5 mfa loss rbe", rbe_hold, 0);
    check("R5 mfa loss crc", crc_hold, 0);
    mfa_sync = 1;

    // R6 saturation: 20 x 7 = 140 errors
    for (int k = 0; k < 20; k++) send_fas(7'b1100100);
    wr(A_FER, 16'd0);
    check("R6 saturate", fer_hold, 127);

    // R8 event in transfer cycle goes to the new interval
    wr(A_FER, 16'd0);
    send_fas(7'b0011000);
    @(negedge clk); reg_wr = 1; reg_addr = A_FER; fas_valid = 1; fas_word = 7'b0011010;
    @(negedge clk); reg_wr = 0; fas_valid = 0; fas_word = 7'b0011011;
    check("R8 old interval", fer_hold, 2);
    wr(A_FER, 16'd0);
    check("R8 new interval", fer_hold, 1);

    // R10 overrun via back-to-back global strobes
    rd(A_STAT, rd_val);
    rd(A_FER, rd_val); rd(A_RBE, rd_val); rd(A_CRC, rd_val);
    pulse_global();
    check("R10 no ovr after reads", ovr_flag, 0);
    check("R7 global sets xfer", xfer_flag, 1);
    pulse_global();
    check("R10 ovr set", ovr_flag, 1);
    rd(A_STAT, rd_val);
    check("R9 status value", rd_val, 3);
    check("R9 flags cleared", {ovr_flag, xfer_flag}, 0);
    rd(A_FER, rd_val); rd(A_RBE, rd_val);
    pulse_global();
    check("R10 partial read ovr", ovr_flag, 1);
    rd(A_STAT, rd_val);
    rd(A_FER, rd_val); rd(A_RBE, rd_val); rd(A_CRC, rd_val);
    pulse_global();
    check("R10 all read no ovr", ovr_flag, 0);

    // R7 / R9 interval timer and interrupt
    rd(A_STAT, rd_val);
    wr(A_PRESC, 16'd4);
    wr(A_CTRL, 16'b0011);
    send_fas(7'b0011010);
    tick(); tick(); tick();
    check("R7 no xfer before interval", xfer_flag, 0);
    check("R7 hold unchanged", fer_hold, 0);
    check("R9 irq low", irq, 0);
    tick();
    check("R7 timer xfer", xfer_flag, 1);
    check("R7 timer hold", fer_hold, 1);
    check("R9 irq high", irq, 1);
    rd(A_STAT, rd_val);
    check("R9 irq cleared", irq, 0);
    wr(A_CTRL, 16'b0010);
    repeat (6) tick();
    check("R7 timer off", xfer_flag, 0);

    finish_run();
  end

endmodule